// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a 32-bit processor core and takes care of the control side of entering an exception. It watches seven request lines: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It picks one winner by fixed priority and works out everything the core needs to redirect execution. That covers the handler vector address, the new status word, and the link and saved-status values to bank into the target mode.

The core reports where it stands through two inputs. A boundary strobe marks the cycle in which an exception may be taken. Alongside it come the address of the instruction at that boundary and the current status word. Reset requests do not wait for a boundary. One clock after acceptance the block raises a single-cycle redirect. In that same cycle it presents the new PC, the new status word and, for every cause except reset, a write strobe for the banked registers of the target mode. Instruction decode, the register file and the return sequences belong to the core.

Top module: `exc_entry_unit`

## Requirements
- R1: During a redirect, new_pc_o carries the cause's vector: reset 0x00, undefined instruction 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R2: A non-reset request is accepted only in a cycle with boundary_i high, and a reset request is accepted in any cycle. Each accepted cycle gives redirect_o high for exactly the following cycle. With nothing accepted, redirect_o stays low.
- R3: When several requests are eligible, the winner follows this order: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt.
- R4: The status word layout is mode in bits 4:0, T in bit 5, F in bit 6 and I in bit 7. The new mode is 10001 for a fast interrupt, 10010 for an interrupt, 10011 for a software interrupt or reset, 10111 for either abort, and 11011 for an undefined instruction. For non-reset causes, bits 31:8 are copied from cur_psr_i.
- R5: For every non-reset cause, the new status word has I set and T cleared. F is set for a fast interrupt and copied unchanged from cur_psr_i for every other cause.
- R6: A reset redirect produces the status word 0x000000D3 (supervisor, I and F set, T and all other bits clear) and does not raise bank_we_o.
- R7: For every non-reset cause, bank_we_o is high together with redirect_o. In that cycle bank_mode_o holds the target mode from R4 and bank_spsr_o holds cur_psr_i as sampled at acceptance.
- R8: bank_lr_o is cur_pc_i as sampled at acceptance plus 8 for a data abort, and plus 4 for every other non-reset cause.
- R9: An interrupt request is ignored while cur_psr_i bit 7 (I) is 1, and a fast interrupt request is ignored while bit 6 (F) is 1. An ignored request alone gives no redirect, and an eligible lower-priority request wins instead.
- R10: While rst is high and afterwards until the first redirect, redirect_o and bank_we_o are 0, new_pc_o is 0 and new_psr_o is 0x000000D3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| boundary_i | input | 1 | Instruction boundary; exceptions other than reset may be taken |
| req_rst_i | input | 1 | Reset exception request |
| req_und_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_dabt_i | input | 1 | Data abort request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_fiq_i | input | 1 | Fast interrupt request |
| cur_pc_i | input | 32 | Address of the instruction at the boundary |
| cur_psr_i | input | 32 | Current status word |
| redirect_o | output | 1 | One-cycle redirect strobe |
| new_pc_o | output | 32 | Vector address to fetch from |
| new_psr_o | output | 32 | Status word after entry |
| bank_we_o | output | 1 | Write strobe for the target mode's link and saved status |
| bank_mode_o | output | 5 | Mode whose banked registers are written |
| bank_lr_o | output | 32 | Link register value |
| bank_spsr_o | output | 32 | Saved status value |

## Verification
The bench targets collisions between causes, such as every line asserted at once, data abort against the fast interrupt, and an interrupt against a prefetch abort. A design with a reordered priority chain would vector to the wrong handler in these cases. It also masks the interrupt and the fast interrupt separately, alone and with a lower-priority cause pending. A design that ignores the mask would redirect anyway, or would choose the masked cause over the one that should win. The remaining stimuli cover a reset request with no boundary, a data abort with no boundary, an entry from a status word with T set, and interrupt entries with F both set and clear. These show up a wrong link offset, a T bit that is not cleared, or an F bit that is forced or dropped where it should be copied.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Status word bit positions
    localparam int PSR_MODE_W = 5;
    localparam int PSR_T_BIT  = 5;
    localparam int PSR_F_BIT  = 6;
    localparam int PSR_I_BIT  = 7;
    localparam int VEC_W      = 5;

    // Source indices in priority order (0 is highest)
    localparam int N_SRC    = 7;
    localparam int SRC_RST  = 0;
    localparam int SRC_DABT = 1;
    localparam int SRC_FIQ  = 2;
    localparam int SRC_IRQ  = 3;
    localparam int SRC_PABT = 4;
    localparam int SRC_UND  = 5;
    localparam int SRC_SWI  = 6;

    typedef enum logic [PSR_MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011
    } mode_e;

    typedef enum logic [2:0] {
        EXC_NONE,
        EXC_RST,
        EXC_DABT,
        EXC_FIQ,
        EXC_IRQ,
        EXC_PABT,
        EXC_UND,
        EXC_SWI
    } exc_e;

    // Status word after a reset or a reset exception: SVC, I and F set
    localparam logic [7:0] RESET_PSR_LO = 8'hD3;

    function automatic logic [VEC_W-1:0] exc_vector(exc_e k);
        case (k)
            EXC_UND:  return 5'h04;
            EXC_SWI:  return 5'h08;
            EXC_PABT: return 5'h0C;
            EXC_DABT: return 5'h10;
            EXC_IRQ:  return 5'h18;
            EXC_FIQ:  return 5'h1C;
            default:  return 5'h00;
        endcase
    endfunction

    function automatic mode_e exc_mode(exc_e k);
        case (k)
            EXC_FIQ:             return MODE_FIQ;
            EXC_IRQ:             return MODE_IRQ;
            EXC_PABT, EXC_DABT:  return MODE_ABT;
            EXC_UND:             return MODE_UND;
            default:             return MODE_SVC;
        endcase
    endfunction

    function automatic logic [3:0] exc_link_off(exc_e k);
        return (k == EXC_DABT) ? 4'd8 : 4'd4;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          boundary_i,
    input  logic [NS-1:0] req_i,
    input  logic          irq_masked_i,
    input  logic          fiq_masked_i,
    output logic [NS-1:0] grant_o
);

    logic [NS-1:0] elig;

    always_comb begin
        elig = req_i & {NS{boundary_i}};
        elig[SRC_RST] = req_i[SRC_RST];
        if (irq_masked_i) elig[SRC_IRQ] = 1'b0;
        if (fiq_masked_i) elig[SRC_FIQ] = 1'b0;
    end

    for (genvar g = 0; g < NS; g++) begin : g_chain
        if (g == 0) begin : g_top
            assign grant_o[g] = elig[g];
        end else begin : g_rest
            assign grant_o[g] = elig[g] & ~(|elig[g-1:0]);
        end
    end

endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
    import exc_pkg::*;
#(
    parameter int PSR_W = 32
) (
    input  exc_e             kind_i,
    input  logic [PSR_W-1:0] cur_psr_i,
    output logic [PSR_W-1:0] new_psr_o,
    output mode_e            mode_o
);

    always_comb begin
        mode_o    = exc_mode(kind_i);
        new_psr_o = cur_psr_i;
        new_psr_o[PSR_MODE_W-1:0] = mode_o;
        new_psr_o[PSR_T_BIT] = 1'b0;
        new_psr_o[PSR_I_BIT] = 1'b1;
        if (kind_i == EXC_FIQ) new_psr_o[PSR_F_BIT] = 1'b1;
        if (kind_i == EXC_RST) begin
            new_psr_o = '0;
            new_psr_o[7:0] = RESET_PSR_LO;
        end
    end

endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  exc_e            kind_i,
    input  logic [PC_W-1:0] cur_pc_i,
    output logic [PC_W-1:0] link_o,
    output logic            bank_we_o
);

    always_comb begin
        link_o    = cur_pc_i + {{(PC_W-4){1'b0}}, exc_link_off(kind_i)};
        bank_we_o = (kind_i != EXC_NONE) && (kind_i != EXC_RST);
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int PSR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boundary_i,
    input  logic                  req_rst_i,
    input  logic                  req_und_i,
    input  logic                  req_swi_i,
    input  logic                  req_pabt_i,
    input  logic                  req_dabt_i,
    input  logic                  req_irq_i,
    input  logic                  req_fiq_i,
    input  logic [PC_W-1:0]       cur_pc_i,
    input  logic [PSR_W-1:0]      cur_psr_i,
    output logic                  redirect_o,
    output logic [PC_W-1:0]       new_pc_o,
    output logic [PSR_W-1:0]      new_psr_o,
    output logic                  bank_we_o,
    output logic [PSR_MODE_W-1:0] bank_mode_o,
    output logic [PC_W-1:0]       bank_lr_o,
    output logic [PSR_W-1:0]      bank_spsr_o
);

    localparam logic [PSR_W-1:0] RESET_PSR = {{(PSR_W-8){1'b0}}, RESET_PSR_LO};

    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] grant;
    exc_e             kind;
    logic             take;
    logic [PSR_W-1:0] psr_nxt;
    mode_e            mode_nxt;
    logic [PC_W-1:0]  link_nxt;
    logic             bank_we_nxt;

    always_comb begin
        req_vec           = '0;
        req_vec[SRC_RST]  = req_rst_i;
        req_vec[SRC_DABT] = req_dabt_i;
        req_vec[SRC_FIQ]  = req_fiq_i;
        req_vec[SRC_IRQ]  = req_irq_i;
        req_vec[SRC_PABT] = req_pabt_i;
        req_vec[SRC_UND]  = req_und_i;
        req_vec[SRC_SWI]  = req_swi_i;
    end

    exc_prio_arb #(.NS(N_SRC)) u_arb (
        .boundary_i   (boundary_i),
        .req_i        (req_vec),
        .irq_masked_i (cur_psr_i[PSR_I_BIT]),
        .fiq_masked_i (cur_psr_i[PSR_F_BIT]),
        .grant_o      (grant)
    );

    always_comb begin
        if      (grant[SRC_RST])  kind = EXC_RST;
        else if (grant[SRC_DABT]) kind = EXC_DABT;
        else if (grant[SRC_FIQ])  kind = EXC_FIQ;
        else if (grant[SRC_IRQ])  kind = EXC_IRQ;
        else if (grant[SRC_PABT]) kind = EXC_PABT;
        else if (grant[SRC_UND])  kind = EXC_UND;
        else if (grant[SRC_SWI])  kind = EXC_SWI;
        else                      kind = EXC_NONE;
        take = (kind != EXC_NONE);
    end

    exc_psr_build #(.PSR_W(PSR_W)) u_psr (
        .kind_i    (kind),
        .cur_psr_i (cur_psr_i),
        .new_psr_o (psr_nxt),
        .mode_o    (mode_nxt)
    );

    exc_link_calc #(.PC_W(PC_W)) u_link (
        .kind_i    (kind),
        .cur_pc_i  (cur_pc_i),
        .link_o    (link_nxt),
        .bank_we_o (bank_we_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_o  <= 1'b0;
            bank_we_o   <= 1'b0;
            new_pc_o    <= '0;
            new_psr_o   <= RESET_PSR;
            bank_mode_o <= MODE_SVC;
            bank_lr_o   <= '0;
            bank_spsr_o <= '0;
        end else begin
            redirect_o <= take;
            bank_we_o  <= bank_we_nxt;
            if (take) begin
                new_pc_o    <= {{(PC_W-VEC_W){1'b0}}, exc_vector(kind)};
                new_psr_o   <= psr_nxt;
                bank_mode_o <= mode_nxt;
                bank_lr_o   <= link_nxt;
                bank_spsr_o <= cur_psr_i;
            end
        end
    end

    // R3: at most one cause granted, and only a requested one
    p_single_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req_vec) == '0));

    // R2: a redirect always traces back to a boundary or a reset request
    p_redirect_cause_r2: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> $past(boundary_i || req_rst_i));

    // R9: a masked interrupt with nothing else pending gives no redirect
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && req_irq_i && cur_psr_i[PSR_I_BIT] && !req_rst_i &&
         !req_dabt_i && !req_fiq_i && !req_pabt_i && !req_und_i && !req_swi_i)
        |=> !redirect_o);

    // R5: fast interrupt entry masks both interrupt kinds
    p_fiq_masks_both_r5: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && new_pc_o == PC_W'(32'h1C)) |->
        (new_psr_o[PSR_I_BIT] && new_psr_o[PSR_F_BIT] &&
         new_psr_o[PSR_MODE_W-1:0] == MODE_FIQ));

    // R6: a reset redirect banks nothing
    p_reset_no_bank_r6: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && new_pc_o == '0) |-> (!bank_we_o && new_psr_o == RESET_PSR));

    // R8: data abort link is the boundary address plus eight
    p_dabt_link_r8: assert property (@(posedge clk) disable iff (rst)
        (bank_we_o && new_pc_o == PC_W'(32'h10)) |->
        (bank_lr_o == $past(cur_pc_i) + PC_W'(8)));

    // R7: banked write only accompanies a redirect
    p_bank_with_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        bank_we_o |-> redirect_o);

endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 1'b0;
    logic        req_rst_i = 1'b0, req_und_i = 1'b0, req_swi_i = 1'b0;
    logic        req_pabt_i = 1'b0, req_dabt_i = 1'b0;
    logic        req_irq_i = 1'b0, req_fiq_i = 1'b0;
    logic [31:0] cur_pc_i = '0;
    logic [31:0] cur_psr_i = '0;
    logic        redirect_o;
    logic [31:0] new_pc_o;
    logic [31:0] new_psr_o;
    logic        bank_we_o;
    logic [4:0]  bank_mode_o;
    logic [31:0] bank_lr_o;
    logic [31:0] bank_spsr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst(rst), .boundary_i(boundary_i),
        .req_rst_i(req_rst_i), .req_und_i(req_und_i), .req_swi_i(req_swi_i),
        .req_pabt_i(req_pabt_i), .req_dabt_i(req_dabt_i),
        .req_irq_i(req_irq_i), .req_fiq_i(req_fiq_i),
        .cur_pc_i(cur_pc_i), .cur_psr_i(cur_psr_i),
        .redirect_o(redirect_o), .new_pc_o(new_pc_o), .new_psr_o(new_psr_o),
        .bank_we_o(bank_we_o), .bank_mode_o(bank_mode_o),
        .bank_lr_o(bank_lr_o), .bank_spsr_o(bank_spsr_o)
    );

    typedef struct {
        string       tag;
        logic        redir;
        logic [31:0] pc;
        logic [31:0] psr;
        logic        we;
        logic [4:0]  mode;
        logic [31:0] lr;
        logic [31:0] spsr;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   mon_en = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Independent model of the requirements
    function automatic exp_t model(string tag, bit bnd, bit r_rst, bit r_dabt, bit r_fiq,
                                   bit r_irq, bit r_pabt, bit r_und, bit r_swi,
                                   logic [31:0] pc, logic [31:0] psr);
        exp_t e;
        logic [4:0] md;
        logic [31:0] vec;
        int off;
        bit set_f;
        e.tag = tag; e.redir = 0; e.we = 0; e.pc = '0; e.psr = '0;
        e.mode = '0; e.lr = '0; e.spsr = '0;
        md = 5'b10011; vec = 0; off = 4; set_f = 0;
        if (r_rst) begin
            e.redir = 1; e.pc = 32'h0; e.psr = 32'h0000_00D3;   // R6
            return e;
        end
        if (!bnd) return e;                                      // R2
        if (r_dabt)                 begin vec = 32'h10; md = 5'b10111; off = 8; end
        else if (r_fiq && !psr[6])  begin vec = 32'h1C; md = 5'b10001; set_f = 1; end
        else if (r_irq && !psr[7])  begin vec = 32'h18; md = 5'b10010; end
        else if (r_pabt)            begin vec = 32'h0C; md = 5'b10111; end
        else if (r_und)             begin vec = 32'h04; md = 5'b11011; end
        else if (r_swi)             begin vec = 32'h08; md = 5'b10011; end
        else return e;                                           // R9
        e.redir = 1; e.we = 1; e.pc = vec; e.mode = md;
        e.psr = {psr[31:8], 1'b1, (set_f ? 1'b1 : psr[6]), 1'b0, md};
        e.lr = pc + off; e.spsr = psr;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus and queue what must follow
    task automatic apply(string tag, bit bnd, bit r_rst, bit r_dabt, bit r_fiq, bit r_irq,
                         bit r_pabt, bit r_und, bit r_swi,
                         logic [31:0] pc, logic [31:0] psr);
        @(negedge clk);
        boundary_i = bnd; req_rst_i = r_rst; req_dabt_i = r_dabt; req_fiq_i = r_fiq;
        req_irq_i = r_irq; req_pabt_i = r_pabt; req_und_i = r_und; req_swi_i = r_swi;
        cur_pc_i = pc; cur_psr_i = psr;
        q.push_back(model(tag, bnd, r_rst, r_dabt, r_fiq, r_irq, r_pabt, r_und, r_swi, pc, psr));
    endtask

    task automatic idle();
        apply("idle R2", 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    endtask

    // Monitor: compare away from the edge, one queued item per cycle
    always @(posedge clk) begin
        if (mon_en) begin
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "R2 redirect", {31'b0, redirect_o}, {31'b0, e.redir});
                chk(e.tag, "R7 bank_we", {31'b0, bank_we_o}, {31'b0, e.we});
                if (e.redir) begin
                    chk(e.tag, "R1 new_pc", new_pc_o, e.pc);
                    chk(e.tag, "R4/R5 new_psr", new_psr_o, e.psr);
                end
                if (e.we) begin
                    chk(e.tag, "R7 bank_mode", {27'b0, bank_mode_o}, {27'b0, e.mode});
                    chk(e.tag, "R7 bank_spsr", bank_spsr_o, e.spsr);
                    chk(e.tag, "R8 bank_lr", bank_lr_o, e.lr);
                end
            end else begin
                chk("unexpected R2", "redirect", {31'b0, redirect_o}, 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    localparam logic [31:0] USR    = 32'hA000_0010;  // user, I=F=0, T=0
    localparam logic [31:0] USR_T  = 32'h2000_0030;  // T set
    localparam logic [31:0] I_MASK = 32'h0000_0090;  // I=1
    localparam logic [31:0] F_MASK = 32'h6000_0050;  // F=1
    localparam logic [31:0] BOTHM  = 32'h0000_00D0;  // I=F=1

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state while held and after release
        chk("R10", "redirect", {31'b0, redirect_o}, 32'h0);
        chk("R10", "new_psr", new_psr_o, 32'h0000_00D3);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "new_pc", new_pc_o, 32'h0);
        chk("R10", "bank_we", {31'b0, bank_we_o}, 32'h0);
        chk("R10", "new_psr after release", new_psr_o, 32'h0000_00D3);
        mon_en = 1'b1;

        // R1/R4/R8 single causes
        apply("und R1", 1, 0, 0, 0, 0, 0, 1, 0, 32'h0000_1000, USR); idle();
        apply("swi R1", 1, 0, 0, 0, 0, 0, 0, 1, 32'h0000_2004, USR); idle();
        apply("pabt R1", 1, 0, 0, 0, 0, 1, 0, 0, 32'h0000_3008, USR); idle();
        apply("dabt R8", 1, 0, 1, 0, 0, 0, 0, 0, 32'h0000_400C, USR); idle();
        apply("irq R4", 1, 0, 0, 0, 1, 0, 0, 0, 32'h0000_5010, USR); idle();
        apply("fiq R5", 1, 0, 0, 1, 0, 0, 0, 0, 32'h0000_6014, USR); idle();
        // R5: T cleared, F copied
        apply("irq T R5", 1, 0, 0, 0, 1, 0, 0, 0, 32'h0000_7000, USR_T); idle();
        apply("pabt Fkeep R5", 1, 0, 0, 0, 0, 1, 0, 0, 32'h0000_7100, F_MASK); idle();
        // R6: reset request with no boundary, user state
        apply("rst R6", 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_8000, USR); idle();
        // R2: no boundary, no entry
        apply("dabt nobnd R2", 0, 0, 1, 0, 0, 0, 0, 0, 32'h0000_9000, USR); idle();
        // R9: masking
        apply("irq masked R9", 1, 0, 0, 0, 1, 0, 0, 0, 32'h0000_A000, I_MASK); idle();
        apply("fiq masked R9", 1, 0, 0, 1, 0, 0, 0, 0, 32'h0000_A100, F_MASK); idle();
        apply("irq masked pabt R9", 1, 0, 0, 0, 1, 1, 0, 0, 32'h0000_A200, I_MASK); idle();
        apply("fiq masked irq R9", 1, 0, 0, 1, 1, 0, 0, 0, 32'h0000_A300, F_MASK); idle();
        apply("both masked swi R9", 1, 0, 0, 1, 1, 0, 0, 1, 32'h0000_A400, BOTHM); idle();
        // R3: priority collisions
        apply("all R3", 1, 1, 1, 1, 1, 1, 1, 1, 32'h0000_B000, USR); idle();
        apply("dabt>fiq R3", 1, 0, 1, 1, 1, 0, 0, 0, 32'h0000_B100, USR); idle();
        apply("fiq>irq R3", 1, 0, 0, 1, 1, 1, 0, 0, 32'h0000_B200, USR); idle();
        apply("irq>pabt R3", 1, 0, 0, 0, 1, 1, 1, 0, 32'h0000_B300, USR); idle();
        apply("pabt>und R3", 1, 0, 0, 0, 0, 1, 1, 0, 32'h0000_B400, USR); idle();
        apply("und>swi R3", 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_B500, USR);
        // R2: back-to-back boundaries give back-to-back redirects
        apply("b2b swi R2", 1, 0, 0, 0, 0, 0, 0, 1, 32'h0000_C000, USR);
        idle(); idle();

        wait (q.size() == 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule